// File: doc/BRIEF.md
# Audio Sample FIFO with Threshold Flags

This block buffers audio samples between a serial audio engine and the system bus. It holds 32 samples in a synchronous first-in first-out store whose memory is written so that block RAM can be inferred. A single programmable threshold sets both the low-water and the high-water flags. The low-water flag compares the fill level against the threshold. The high-water flag compares the free space against the same threshold.

The same block serves either direction of a link, chosen by a parameter. In the receive build, the demand-mode DMA request follows "FIFO holds data" and does not depend on the threshold. In the transmit build, the request stays asserted while the FIFO is below its high-water mark, so the DMA engine keeps topping it up. A FIFO enable gates all traffic and flushes the store when it is cleared. Writes to a full FIFO and reads from an empty one are dropped and recorded in sticky error bits.

Top module: `audio_fifo_dip`

## Requirements
- R1: Accepted samples come out in write order, up to 32 stored. A read accepted at a clock edge drives `rd_data` and pulses `rd_vld` high for the cycle that follows that edge.
- R2: All status outputs are registered and reflect the fill level after the edge. `empty` is 1 exactly when the level is 0, and `full` is 1 exactly when the level is 32.
- R3: `almost_empty` is 1 when `dipstick` is non-zero and the level is strictly below `dipstick`.
- R4: `almost_full` is 1 when `dipstick` is non-zero and level + `dipstick` > 32. With `dipstick` = 32 this means any level above zero.
- R5: With `dipstick` = 0, both `almost_empty` and `almost_full` are 0 at every fill level.
- R6: In the receive build (IS_TX = 0), `dma_req` = `dma_en` AND `fifo_en` AND NOT `empty`, for any `dipstick`.
- R7: In the transmit build (IS_TX = 1), `dma_req` = `dma_en` AND `fifo_en` AND NOT `almost_full`.
- R8: While `dma_en` is 0, `dma_req` is 0 in both builds.
- R9: While `fifo_en` is 0, writes are not stored and reads give no `rd_vld`. An edge with `fifo_en` low empties the FIFO, so `empty` = 1 afterwards.
- R10: A write while enabled and full is dropped and sets the sticky `overflow` bit.
- R11: A read while enabled and empty sets the sticky `underflow` bit. `err_clr` clears both sticky bits, but an error in the same cycle keeps its bit set.
- R12: A synchronous `rst` gives `empty` = 1, and `full`, `almost_empty`, `almost_full`, `dma_req`, `rd_vld`, `overflow` and `underflow` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Enables traffic; low flushes the store |
| dma_en | input | 1 | Enables the DMA request |
| dipstick | input | DIP_W | Shared threshold for both almost flags |
| err_clr | input | 1 | Clears the sticky error bits |
| wr_valid | input | 1 | Write request |
| wr_data | input | DATA_W | Sample to write |
| rd_ready | input | 1 | Read request |
| rd_data | output | DATA_W | Sample read out, registered |
| rd_vld | output | 1 | `rd_data` holds a newly read sample |
| empty | output | 1 | Fill level is zero |
| full | output | 1 | Fill level is DEPTH |
| almost_empty | output | 1 | Level below threshold |
| almost_full | output | 1 | Free space below threshold |
| dma_req | output | 1 | Demand-mode DMA request |
| overflow | output | 1 | Sticky: write was dropped |
| underflow | output | 1 | Sticky: read of empty FIFO |

## Verification
The assertions check on every cycle:
- that `empty` and `full` never hold together;
- that a zero threshold silences both almost flags;
- that the DMA request is off when `dma_en` is low;
- that the request follows `empty` or `almost_full`, depending on the build;
- that a disabled FIFO has no read data and reports empty;
- that the error bits are sticky and are set by illegal accesses.

Only the bench's reference queue can show that samples leave in order with the correct data. The same holds for the exact threshold crossing at each dipstick value (0, 32, above 32) and for the flush when the enable is cleared.

// File: rtl/afd_pkg.sv
package afd_pkg;
  typedef struct packed {
    logic empty;
    logic full;
    logic low;
    logic high;
    logic req;
  } afd_flags_t;

  localparam afd_flags_t AFD_FLAGS_RST = '{empty: 1'b1, full: 1'b0, low: 1'b0, high: 1'b0, req: 1'b0};
endpackage

// File: rtl/afd_ram.sv
module afd_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/afd_ctrl.sv
module afd_ctrl #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          wr_valid,
  input  logic          rd_ready,
  input  logic          err_clr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] level_nxt,
  output logic          rd_vld,
  output logic          overflow,
  output logic          underflow
);
  localparam logic [CW-1:0] LVL_MAX  = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [CW-1:0] level_q;
  logic [AW-1:0] wp_q, rp_q;
  logic          is_full, is_empty, push, pop, ovf_hit, unf_hit;

  assign is_full  = (level_q == LVL_MAX);
  assign is_empty = (level_q == '0);
  assign push     = fifo_en && wr_valid && !is_full;
  assign pop      = fifo_en && rd_ready && !is_empty;
  assign ovf_hit  = fifo_en && wr_valid && is_full;
  assign unf_hit  = fifo_en && rd_ready && is_empty;

  always_comb begin
    if (!fifo_en)         level_nxt = '0;
    else if (push && !pop) level_nxt = level_q + 1'b1;
    else if (pop && !push) level_nxt = level_q - 1'b1;
    else                   level_nxt = level_q;
  end

  assign we    = push;
  assign waddr = wp_q;
  assign re    = pop;
  assign raddr = rp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q   <= '0;
      wp_q      <= '0;
      rp_q      <= '0;
      rd_vld    <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      level_q <= level_nxt;
      rd_vld  <= pop;
      if (!fifo_en) begin
        wp_q <= '0;
        rp_q <= '0;
      end else begin
        if (push) wp_q <= (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
        if (pop)  rp_q <= (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
      end
      overflow  <= ovf_hit || (overflow  && !err_clr);
      underflow <= unf_hit || (underflow && !err_clr);
    end
  end
endmodule

// File: rtl/afd_flags.sv
module afd_flags
  import afd_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DIP_W = 6,
  parameter bit IS_TX = 1'b0,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             dma_en,
  input  logic [DIP_W-1:0] dipstick,
  input  logic [CW-1:0]    level_nxt,
  output afd_flags_t       flags
);
  afd_flags_t nxt;
  logic       dip_on, req_cond;
  int         lvl, dip;

  assign lvl    = int'(level_nxt);
  assign dip    = int'(dipstick);
  assign dip_on = (dipstick != '0);

  always_comb begin
    nxt.empty = (lvl == 0);
    nxt.full  = (lvl == DEPTH);
    nxt.low   = dip_on && (lvl < dip);
    nxt.high  = dip_on && ((lvl + dip) > DEPTH);
  end

  generate
    if (IS_TX) begin : g_tx
      assign req_cond = !nxt.high;
    end else begin : g_rx
      assign req_cond = !nxt.empty;
    end
  endgenerate

  assign nxt.req = dma_en && fifo_en && req_cond;

  always_ff @(posedge clk) begin
    if (rst) flags <= AFD_FLAGS_RST;
    else     flags <= nxt;
  end
endmodule

// File: rtl/audio_fifo_dip.sv
module audio_fifo_dip
  import afd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int DIP_W  = 6,
  parameter bit IS_TX  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              dma_en,
  input  logic [DIP_W-1:0]  dipstick,
  input  logic              err_clr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              empty,
  output logic              full,
  output logic              almost_empty,
  output logic              almost_full,
  output logic              dma_req,
  output logic              overflow,
  output logic              underflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] level_nxt;
  afd_flags_t    flags;

  afd_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .wr_valid(wr_valid),
    .rd_ready(rd_ready), .err_clr(err_clr), .we(we), .waddr(waddr),
    .re(re), .raddr(raddr), .level_nxt(level_nxt), .rd_vld(rd_vld),
    .overflow(overflow), .underflow(underflow)
  );

  afd_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .re(re), .raddr(raddr), .rdata(rd_data)
  );

  afd_flags #(.DEPTH(DEPTH), .DIP_W(DIP_W), .IS_TX(IS_TX)) u_flags (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_en(dma_en),
    .dipstick(dipstick), .level_nxt(level_nxt), .flags(flags)
  );

  assign empty        = flags.empty;
  assign full         = flags.full;
  assign almost_empty = flags.low;
  assign almost_full  = flags.high;
  assign dma_req      = flags.req;
endmodule

// File: rtl/afd_checker.sv
module afd_checker #(
  parameter int DIP_W = 6,
  parameter bit IS_TX = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_en,
  input logic             dma_en,
  input logic [DIP_W-1:0] dipstick,
  input logic             err_clr,
  input logic             wr_valid,
  input logic             rd_ready,
  input logic             rd_vld,
  input logic             empty,
  input logic             full,
  input logic             almost_empty,
  input logic             almost_full,
  input logic             dma_req,
  input logic             overflow,
  input logic             underflow
);
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst) !(empty && full)); // R2
  AST_DIP_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(dipstick) == '0) |-> (!almost_empty && !almost_full)); // R5
  AST_DMA_GATED: assert property (@(posedge clk) disable iff (rst) !$past(dma_en) |-> !dma_req); // R8
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(fifo_en) |-> (!rd_vld && empty)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(overflow) && !$past(err_clr)) |-> overflow); // R10
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    $past(fifo_en && wr_valid && full) |-> overflow); // R10
  AST_UNF_SET: assert property (@(posedge clk) disable iff (rst)
    $past(fifo_en && rd_ready && empty) |-> underflow); // R11

  generate
    if (IS_TX) begin : g_tx
      AST_TX_REQ: assert property (@(posedge clk) disable iff (rst)
        $past(dma_en && fifo_en) |-> (dma_req == !almost_full)); // R7
    end else begin : g_rx
      AST_RX_REQ: assert property (@(posedge clk) disable iff (rst)
        $past(dma_en && fifo_en) |-> (dma_req == !empty)); // R6
    end
  endgenerate
endmodule

bind audio_fifo_dip afd_checker #(.DIP_W(DIP_W), .IS_TX(IS_TX)) u_afd_chk (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_en(dma_en), .dipstick(dipstick),
  .err_clr(err_clr), .wr_valid(wr_valid), .rd_ready(rd_ready), .rd_vld(rd_vld),
  .empty(empty), .full(full), .almost_empty(almost_empty), .almost_full(almost_full),
  .dma_req(dma_req), .overflow(overflow), .underflow(underflow)
);

// File: tb/tb_audio_fifo_dip.sv
module tb_audio_fifo_dip;
  localparam int DW = 16;
  localparam int N  = 32;

  logic clk = 1'b0;
  logic rst, fifo_en, dma_en, err_clr, wr_valid, rd_ready;
  logic [5:0]    dipstick;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data, rd_data_t;
  logic rd_vld, empty, full, ae, af, req, ovf, unf;
  logic rd_vld_t, empty_t, full_t, ae_t, af_t, req_t, ovf_t, unf_t;

  always #4 clk = ~clk;

  audio_fifo_dip #(.IS_TX(1'b0)) dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_en(dma_en), .dipstick(dipstick),
    .err_clr(err_clr), .wr_valid(wr_valid), .wr_data(wr_data), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_vld(rd_vld), .empty(empty), .full(full),
    .almost_empty(ae), .almost_full(af), .dma_req(req), .overflow(ovf), .underflow(unf)
  );

  audio_fifo_dip #(.IS_TX(1'b1)) dut_tx (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_en(dma_en), .dipstick(dipstick),
    .err_clr(err_clr), .wr_valid(wr_valid), .wr_data(wr_data), .rd_ready(rd_ready),
    .rd_data(rd_data_t), .rd_vld(rd_vld_t), .empty(empty_t), .full(full_t),
    .almost_empty(ae_t), .almost_full(af_t), .dma_req(req_t), .overflow(ovf_t), .underflow(unf_t)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] q [$];
  logic [DW-1:0] m_data;
  bit m_vld, m_empty, m_full, m_ae, m_af, m_rxreq, m_txreq, m_ovf, m_unf;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int n;
    bit ph, pp;
    if (rst) begin
      q.delete();
      m_vld = 0; m_ovf = 0; m_unf = 0;
      m_empty = 1; m_full = 0; m_ae = 0; m_af = 0; m_rxreq = 0; m_txreq = 0;
      return;
    end
    m_vld = 0;
    if (!fifo_en) begin
      q.delete();
      m_ovf = m_ovf && !err_clr;
      m_unf = m_unf && !err_clr;
    end else begin
      n  = q.size();
      ph = wr_valid && (n < N);
      pp = rd_ready && (n > 0);
      m_ovf = (wr_valid && n == N) || (m_ovf && !err_clr);
      m_unf = (rd_ready && n == 0) || (m_unf && !err_clr);
      if (pp) begin m_data = q.pop_front(); m_vld = 1; end
      if (ph) q.push_back(wr_data);
    end
    n = q.size();
    m_empty = (n == 0);
    m_full  = (n == N);
    m_ae    = (dipstick != 0) && (n < int'(dipstick));
    m_af    = (dipstick != 0) && (n + int'(dipstick) > N);
    m_rxreq = dma_en && fifo_en && (n != 0);
    m_txreq = dma_en && fifo_en && !m_af;
  endtask

  task automatic compare();
    chk("R1 rd_vld", rd_vld, m_vld);
    if (m_vld) chk("R1 rd_data", rd_data, m_data);
    chk("R2 empty", empty, m_empty);
    chk("R2 full", full, m_full);
    chk("R3 almost_empty", ae, m_ae);
    chk("R4 almost_full", af, m_af);
    chk("R6 rx dma_req", req, m_rxreq);
    chk("R7 tx dma_req", req_t, m_txreq);
    chk("R10 overflow", ovf, m_ovf);
    chk("R11 underflow", unf, m_unf);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    wr_valid = 0; rd_ready = 0; err_clr = 0;
  endtask

  initial begin
    rst = 1; fifo_en = 0; dma_en = 0; dipstick = 6'd0; wr_data = '0;
    idle();
    repeat (3) cyc();
    // R12 reset state
    chk("R12 empty", empty, 1); chk("R12 full", full, 0);
    chk("R12 almost", {30'd0, ae, af}, 0); chk("R12 dma_req", {30'd0, req, req_t}, 0);
    chk("R12 rd_vld", rd_vld, 0); chk("R12 errors", {30'd0, ovf, unf}, 0);
    rst = 0;

    // R9: writes while disabled are not stored
    dipstick = 6'd8; dma_en = 1; wr_valid = 1; wr_data = 16'hdead;
    repeat (3) cyc();
    idle(); fifo_en = 1; rd_ready = 1; cyc();
    chk("R9 disabled write dropped", empty, 1);
    chk("R8 tx req with enables", req_t, 1);
    idle(); err_clr = 1; cyc(); idle();

    // R1/R2/R10 fill past full
    for (int i = 0; i < N + 2; i++) begin
      wr_valid = 1; wr_data = DW'(16'h1000 + i); cyc();
    end
    idle();
    chk("R2 full after fill", full, 1);
    chk("R10 overflow set", ovf, 1);
    chk("R7 tx req off when almost full", req_t, 0);
    cyc();
    chk("R10 overflow sticky", ovf, 1);

    // drain past empty
    for (int i = 0; i < N + 1; i++) begin rd_ready = 1; cyc(); end
    idle();
    chk("R11 underflow set", unf, 1);
    chk("R6 rx req off when empty", req, 0);
    err_clr = 1; rd_ready = 1; cyc(); idle();
    chk("R11 same-cycle error wins", unf, 1);
    err_clr = 1; cyc(); idle();
    chk("R11 cleared", {30'd0, ovf, unf}, 0);

    // R4/R5 threshold sweep: 0, 32, 40, 1
    dipstick = 6'd0;
    for (int i = 0; i < N; i++) begin
      wr_valid = 1; wr_data = DW'(i * 7); cyc();
      chk("R5 dip zero quiet", {30'd0, ae, af}, 0);
    end
    idle();
    dipstick = 6'd32;
    for (int i = 0; i < N; i++) begin
      rd_ready = 1; cyc();
    end
    idle(); cyc();
    chk("R4 dip32 empty", af, 0);
    wr_valid = 1; wr_data = 16'h55aa; cyc(); idle();
    chk("R4 dip32 acts as not-empty", af, 1);
    dipstick = 6'd40; cyc();
    chk("R3 dip40 almost_empty", ae, 1);
    chk("R4 dip40 almost_full", af, 1);
    dipstick = 6'd1; cyc();
    chk("R3 dip1 level1", ae, 0);

    // R9 flush, R8 dma gating
    fifo_en = 0; cyc();
    chk("R9 flushed", empty, 1);
    fifo_en = 1; dma_en = 0; wr_valid = 1; wr_data = 16'h0bad; cyc(); idle();
    chk("R8 rx req gated", req, 0);
    chk("R8 tx req gated", req_t, 0);
    dma_en = 1;

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      wr_valid = ($urandom % 3) != 0;
      rd_ready = ($urandom % 2) != 0;
      wr_data  = DW'($urandom);
      err_clr  = ($urandom % 50) == 0;
      if ((i % 97) == 0) dipstick = 6'($urandom);
      if ((i % 211) == 0) fifo_en = 0; else fifo_en = 1;
      if ((i % 331) == 5) dma_en = ~dma_en;
      cyc();
    end
    idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule